// File: doc/BRIEF.md
# Paired-Slot Instruction Issue Sequencer

This block sits between instruction fetch and a single-ported execute unit. It takes one 32-bit fetched word. From the two top bits it works out whether the word holds one wide operation or two 15-bit short operations. It then hands the operations to the execute port one at a time. Each issued operation carries a slot tag and the 6-bit key that the downstream decoder uses to index its opcode tables.

For a pair, the sequencer picks which half goes first. After the first half completes, it looks at the execute unit's feedback (redirect, exception, condition flag) to decide whether the second half issues or is dropped. Some short operations are condition operations: their key matches a parameterised mask/value pattern. When one of these appears in a parallel pair, it issues first, and its partner issues only if the condition flag it produced is set.

The execute unit acknowledges each operation with `ex_done`, and the feedback lines are only looked at in that cycle. After the last operation of a word, or after a squash, the block pulses `word_done` once and becomes ready for the next word.

Top module: `issue_seq`

## Requirements
- R1: Out of reset and whenever no word is in flight, `word_ready`=1, `op_valid`=0 and `word_done`=0. A word is taken in a cycle where `word_valid` and `word_ready` are both high.
- R2: Format code `word_data[31:30]`=11 is one wide operation. `op_payload` = `word_data[29:0]`, the tag is LONG (1), `op_key` = `word_data[29:24]`, and exactly one operation issues whatever the feedback.
- R3: Short halves: the left half is `word_data[29:15]` and the right half is `word_data[14:0]`. Each is issued zero-extended to 30 bits, with `op_key` = half bits 14:9.
- R4: Code 01 issues the left half first (tag LEFT=2) and then the right half (tag RIGHT=3). Code 10 issues the right half first (RIGHT) and then the left half (LEFT).
- R5: In a code 01 or 10 pair, if `ex_redirect` or `ex_exception` is high with the first operation's `ex_done`, the second operation never issues.
- R6: Code 00 without condition operations issues the left half first (tag LPAR=4) and then the right half (tag RPAR=5). The right half is dropped only if `ex_exception` accompanies the left half's `ex_done`; `ex_redirect` does not drop it.
- R7: A short half is a condition operation when (key & COND_MASK) == COND_KEY, by default keys 0x3E and 0x3F. In a code 00 pair, the condition half issues first, and the left half wins if both qualify. The condition half is tagged with its own container (LEFT or RIGHT) and its partner with the other. The partner issues only if `ex_cond` is high with the first `ex_done`.
- R8: While `op_valid` is high and `ex_done` is low, `op_payload`, `op_key` and `op_slot` hold steady.
- R9: `word_done` is a single-cycle pulse, exactly once per word, in the cycle after the final `ex_done`. `word_ready` returns in the following cycle.
- R10: `word_valid` raised while a word is in flight is ignored: no extra operation is issued and no extra `word_done` appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Fetched word present |
| word_data | input | 32 | Fetched instruction word |
| word_ready | output | 1 | Sequencer idle, will take a word |
| op_valid | output | 1 | An operation is presented to execute |
| op_slot | output | 3 | Slot tag: 0 none, 1 LONG, 2 LEFT, 3 RIGHT, 4 LPAR, 5 RPAR |
| op_key | output | 6 | Decode index key of the issued operation |
| op_payload | output | 30 | Issued operation bits |
| ex_done | input | 1 | Execute finished the presented operation |
| ex_redirect | input | 1 | Finished operation changed the program counter |
| ex_exception | input | 1 | Finished operation raised an exception |
| ex_cond | input | 1 | Execute-condition flag after the finished operation |
| word_done | output | 1 | One-cycle pulse: word fully handled |

## Verification
The bench targets the ways a pair can be cut short. A sequencer that treated redirects in parallel pairs like sequential ones would lose the right half after a branch. One that ignored the condition flag would always issue the partner. One with the code 01 and code 10 orders swapped would produce the tags in reverse order. It also aims at words whose halves both carry condition keys, where a wrong priority puts the right half first. Long words are given an exception, which a design that gated long words would turn into a missing or doubled `word_done`. Stray `word_valid` pulses are driven while the execute unit stalls, which would show up as extra or corrupted operations. Execute latency is varied to expose payloads that change before the handshake.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int WORD_W  = 32;
  localparam int PAY_W   = 30;
  localparam int SHORT_W = 15;
  localparam int KEY_W   = 6;
  localparam int PAD_W   = PAY_W - SHORT_W;

  typedef enum logic [2:0] {
    SLOT_NONE  = 3'd0,
    SLOT_LONG  = 3'd1,
    SLOT_LEFT  = 3'd2,
    SLOT_RIGHT = 3'd3,
    SLOT_LPAR  = 3'd4,
    SLOT_RPAR  = 3'd5
  } slot_t;

  typedef enum logic [1:0] {
    GATE_NONE = 2'd0,
    GATE_SEQ  = 2'd1,
    GATE_PAR  = 2'd2,
    GATE_COND = 2'd3
  } gate_t;

  typedef struct packed {
    slot_t              tag0;
    slot_t              tag1;
    logic [PAY_W-1:0]   pay0;
    logic [PAY_W-1:0]   pay1;
    logic               two;
    gate_t              gate;
  } plan_t;

  // Zero-extend one short half to the payload width.
  function automatic logic [PAY_W-1:0] widen(input logic [SHORT_W-1:0] s);
    return {{PAD_W{1'b0}}, s};
  endfunction

  // Condition-operation match on a decode key.
  function automatic logic key_match(input logic [KEY_W-1:0] k,
                                     input logic [KEY_W-1:0] msk,
                                     input logic [KEY_W-1:0] val);
    return (k & msk) == val;
  endfunction
endpackage

// File: rtl/issue_classify.sv
module issue_classify
  import issue_pkg::*;
#(
  parameter logic [KEY_W-1:0] COND_MASK = 6'h3E,
  parameter logic [KEY_W-1:0] COND_KEY  = 6'h3E
) (
  input  logic [WORD_W-1:0] word,
  output plan_t             plan
);
  localparam int LHI = 2 * SHORT_W - 1;
  localparam int KLO = SHORT_W - KEY_W;

  logic [SHORT_W-1:0] left_h, right_h;
  logic               left_c, right_c;

  assign left_h  = word[LHI:SHORT_W];
  assign right_h = word[SHORT_W-1:0];
  assign left_c  = key_match(left_h[SHORT_W-1:KLO], COND_MASK, COND_KEY);
  assign right_c = key_match(right_h[SHORT_W-1:KLO], COND_MASK, COND_KEY);

  always_comb begin
    plan.tag0 = SLOT_LEFT;
    plan.tag1 = SLOT_RIGHT;
    plan.pay0 = widen(left_h);
    plan.pay1 = widen(right_h);
    plan.two  = 1'b1;
    plan.gate = GATE_SEQ;
    unique case (word[WORD_W-1:WORD_W-2])
      2'b11: begin
        plan.tag0 = SLOT_LONG;
        plan.tag1 = SLOT_NONE;
        plan.pay0 = word[PAY_W-1:0];
        plan.pay1 = '0;
        plan.two  = 1'b0;
        plan.gate = GATE_NONE;
      end
      2'b01: begin
        plan.gate = GATE_SEQ;
      end
      2'b10: begin
        plan.tag0 = SLOT_RIGHT;
        plan.tag1 = SLOT_LEFT;
        plan.pay0 = widen(right_h);
        plan.pay1 = widen(left_h);
        plan.gate = GATE_SEQ;
      end
      default: begin
        if (left_c) begin
          plan.gate = GATE_COND;
        end else if (right_c) begin
          plan.tag0 = SLOT_RIGHT;
          plan.tag1 = SLOT_LEFT;
          plan.pay0 = widen(right_h);
          plan.pay1 = widen(left_h);
          plan.gate = GATE_COND;
        end else begin
          plan.tag0 = SLOT_LPAR;
          plan.tag1 = SLOT_RPAR;
          plan.gate = GATE_PAR;
        end
      end
    endcase
  end
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_pkg::*;
(
  input  gate_t gate,
  input  logic  redirect,
  input  logic  exception,
  input  logic  cond,
  output logic  allow
);
  always_comb begin
    unique case (gate)
      GATE_SEQ:  allow = !(redirect || exception);
      GATE_PAR:  allow = !exception;
      GATE_COND: allow = cond;
      default:   allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/issue_keysel.sv
module issue_keysel
  import issue_pkg::*;
(
  input  logic             is_long,
  input  logic [KEY_W-1:0] long_field,
  input  logic [KEY_W-1:0] short_field,
  output logic [KEY_W-1:0] key
);
  assign key = is_long ? long_field : short_field;
endmodule

// File: rtl/issue_seq.sv
module issue_seq
  import issue_pkg::*;
#(
  parameter logic [KEY_W-1:0] COND_MASK = 6'h3E,
  parameter logic [KEY_W-1:0] COND_KEY  = 6'h3E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              op_valid,
  output logic [2:0]        op_slot,
  output logic [KEY_W-1:0]  op_key,
  output logic [PAY_W-1:0]  op_payload,
  input  logic              ex_done,
  input  logic              ex_redirect,
  input  logic              ex_exception,
  input  logic              ex_cond,
  output logic              word_done
);
  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND, ST_FIN} st_t;

  st_t   state;
  plan_t plan_new, plan_q;
  logic  allow;

  // Named events, used by the bound checker.
  logic in_first, in_second, evt_accept, evt_first_ack, evt_squash;
  logic pair_seq, pair_cond;

  issue_classify #(.COND_MASK(COND_MASK), .COND_KEY(COND_KEY)) u_cls (
    .word (word_data),
    .plan (plan_new)
  );

  issue_gate u_gate (
    .gate      (plan_q.gate),
    .redirect  (ex_redirect),
    .exception (ex_exception),
    .cond      (ex_cond),
    .allow     (allow)
  );

  assign in_first      = (state == ST_FIRST);
  assign in_second     = (state == ST_SECOND);
  assign evt_accept    = word_valid && (state == ST_IDLE);
  assign evt_first_ack = in_first && ex_done;
  assign evt_squash    = evt_first_ack && plan_q.two && !allow;
  assign pair_seq      = (plan_q.gate == GATE_SEQ);
  assign pair_cond     = (plan_q.gate == GATE_COND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      plan_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (evt_accept) begin
          plan_q <= plan_new;
          state  <= ST_FIRST;
        end
        ST_FIRST: if (ex_done) begin
          state <= (plan_q.two && allow) ? ST_SECOND : ST_FIN;
        end
        ST_SECOND: if (ex_done) state <= ST_FIN;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign word_ready = (state == ST_IDLE);
  assign word_done  = (state == ST_FIN);
  assign op_valid   = in_first || in_second;

  always_comb begin
    op_slot    = SLOT_NONE;
    op_payload = '0;
    if (in_first) begin
      op_slot    = plan_q.tag0;
      op_payload = plan_q.pay0;
    end else if (in_second) begin
      op_slot    = plan_q.tag1;
      op_payload = plan_q.pay1;
    end
  end

  issue_keysel u_key (
    .is_long     (op_slot == SLOT_LONG),
    .long_field  (op_payload[PAY_W-1:PAY_W-KEY_W]),
    .short_field (op_payload[SHORT_W-1:SHORT_W-KEY_W]),
    .key         (op_key)
  );
endmodule

// File: rtl/issue_seq_chk.sv
module issue_seq_chk
  import issue_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             word_ready,
  input logic             op_valid,
  input logic [2:0]       op_slot,
  input logic [KEY_W-1:0] op_key,
  input logic [PAY_W-1:0] op_payload,
  input logic             ex_done,
  input logic             ex_redirect,
  input logic             ex_exception,
  input logic             ex_cond,
  input logic             word_done,
  input logic             in_first,
  input logic             evt_squash,
  input logic             pair_seq,
  input logic             pair_cond
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (!op_valid && !word_done));

  p_long_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && ex_done && op_slot == SLOT_LONG) |=> word_done);

  p_seq_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_first && ex_done && pair_seq && (ex_redirect || ex_exception)) |=> word_done);

  p_rpar_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_first |-> (op_slot != SLOT_RPAR));

  p_cond_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_first && ex_done && pair_cond && !ex_cond) |=> word_done);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !ex_done) |=> (op_valid && $stable(op_payload) && $stable(op_slot) && $stable(op_key)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (!word_done && word_ready));

  p_squash_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_squash |=> (word_done && !op_valid));
endmodule

bind issue_seq issue_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .word_ready   (word_ready),
  .op_valid     (op_valid),
  .op_slot      (op_slot),
  .op_key       (op_key),
  .op_payload   (op_payload),
  .ex_done      (ex_done),
  .ex_redirect  (ex_redirect),
  .ex_exception (ex_exception),
  .ex_cond      (ex_cond),
  .word_done    (word_done),
  .in_first     (in_first),
  .evt_squash   (evt_squash),
  .pair_seq     (pair_seq),
  .pair_cond    (pair_cond)
);

// File: tb/tb_issue_seq.sv
module tb_issue_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        word_ready, op_valid, word_done;
  logic [2:0]  op_slot;
  logic [5:0]  op_key;
  logic [29:0] op_payload;
  logic        ex_done = 1'b0, ex_redirect = 1'b0, ex_exception = 1'b0, ex_cond = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [39:0] exp_q[$];
  string       req_q[$];

  always #5 clk = ~clk;

  issue_seq dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
    .word_ready(word_ready), .op_valid(op_valid), .op_slot(op_slot), .op_key(op_key),
    .op_payload(op_payload), .ex_done(ex_done), .ex_redirect(ex_redirect),
    .ex_exception(ex_exception), .ex_cond(ex_cond), .word_done(word_done)
  );

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected item: {is_done, tag[2:0], key[5:0], payload[29:0]}
  function automatic logic [39:0] op_item(input logic [2:0] tag, input logic [29:0] pay);
    logic [5:0] k = (tag == 3'd1) ? pay[29:24] : pay[14:9];
    return {1'b0, tag, k, pay};
  endfunction

  task automatic push(input logic [39:0] it, input string req);
    exp_q.push_back(it);
    req_q.push_back(req);
  endtask

  function automatic bit is_cnd(input logic [5:0] k);
    return k >= 6'h3E;
  endfunction

  // Driver-side model of the requirements.
  task automatic expect_word(input logic [31:0] w, input bit red, input bit exc, input bit cnd);
    logic [29:0] lp = {15'd0, w[29:15]};
    logic [29:0] rp = {15'd0, w[14:0]};
    case (w[31:30])
      2'b11: push(op_item(3'd1, w[29:0]), "R2");
      2'b01: begin
        push(op_item(3'd2, lp), "R4");
        if (!(red || exc)) push(op_item(3'd3, rp), "R5");
      end
      2'b10: begin
        push(op_item(3'd3, rp), "R4");
        if (!(red || exc)) push(op_item(3'd2, lp), "R5");
      end
      default: begin
        if (is_cnd(w[29:24])) begin
          push(op_item(3'd2, lp), "R7");
          if (cnd) push(op_item(3'd3, rp), "R7");
        end else if (is_cnd(w[14:9])) begin
          push(op_item(3'd3, rp), "R7");
          if (cnd) push(op_item(3'd2, lp), "R7");
        end else begin
          push(op_item(3'd4, lp), "R6");
          if (!exc) push(op_item(3'd5, rp), "R6");
        end
      end
    endcase
    push({1'b1, 39'd0}, "R9");
  endtask

  // Monitor: pops and compares on each handshake and done pulse.
  always @(negedge clk) begin
    #2;
    if (rst_n && op_valid && ex_done) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected op", {1'b0, op_slot, op_key, op_payload}, '0);
      else check({1'b0, op_slot, op_key, op_payload} == exp_q[0], req_q[0],
                 {1'b0, op_slot, op_key, op_payload}, exp_q[0]);
      if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(req_q.pop_front()); end
    end
    if (rst_n && word_done) begin
      if (exp_q.size() == 0) check(1'b0, "R9 unexpected done", 40'h1, '0);
      else check(exp_q[0] == {1'b1, 39'd0}, {req_q[0], " R9 done"}, {1'b1, 39'd0}, exp_q[0]);
      if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(req_q.pop_front()); end
    end
  end

  task automatic run_word(input logic [31:0] w, input bit red, input bit exc, input bit cnd,
                          input int lat, input bit poke);
    int n = 0;
    int wc = 0;
    logic [29:0] held = '0;
    expect_word(w, red, exc, cnd);
    @(negedge clk);
    check(word_ready == 1'b1, "R1 ready before word", {39'd0, word_ready}, 40'h1);
    word_data = w;
    word_valid = 1'b1;
    @(negedge clk);
    word_valid = 1'b0;
    word_data = '0;
    forever begin
      ex_done = 1'b0; ex_redirect = 1'b0; ex_exception = 1'b0; ex_cond = 1'b0;
      word_valid = 1'b0;
      if (word_done) break;
      if (op_valid) begin
        if (wc == 0) held = op_payload;
        else check(op_payload == held, "R8 hold", {10'd0, op_payload}, {10'd0, held});
        if (poke && wc == 1) begin
          word_valid = 1'b1;
          word_data = 32'hC000_0BAD;   // R10: must be ignored while busy
        end
        if (wc == lat) begin
          ex_done = 1'b1;
          if (n == 0) begin ex_redirect = red; ex_exception = exc; ex_cond = cnd; end
          n++;
          wc = 0;
        end else wc++;
      end
      @(negedge clk);
    end
    @(negedge clk);
    check(word_ready == 1'b1 && word_done == 1'b0, "R9 ready after done",
          {38'd0, word_ready, word_done}, 40'h2);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(word_ready == 1'b1 && op_valid == 1'b0 && word_done == 1'b0, "R1 reset",
          {37'd0, word_ready, op_valid, word_done}, 40'h4);
    rst_n = 1'b1;
    @(negedge clk);
    check(word_ready == 1'b1 && op_valid == 1'b0 && op_slot == 3'd0, "R1 idle",
          {36'd0, word_ready, op_slot}, 40'h8);

    run_word(32'hC5A5_1234, 0, 0, 0, 0, 0);   // R2 long
    run_word(32'hFFFF_FFFF, 0, 1, 0, 2, 0);   // R2 long with exception still one op
    run_word(32'h4123_4567, 0, 0, 0, 1, 0);   // R3 R4 left then right
    run_word(32'h8765_4321, 0, 0, 0, 0, 0);   // R4 right then left
    run_word(32'h4ABC_DEF0, 1, 0, 0, 0, 0);   // R5 redirect drops second
    run_word(32'h8ABC_DEF0, 0, 1, 0, 1, 0);   // R5 exception drops second
    run_word(32'h1234_5678, 0, 0, 0, 0, 0);   // R6 parallel both
    run_word(32'h1234_5678, 1, 0, 0, 0, 0);   // R6 redirect keeps right
    run_word(32'h1234_5678, 0, 1, 0, 0, 0);   // R6 exception drops right
    run_word(32'h3E12_3456, 0, 0, 1, 0, 0);   // R7 left cond, flag set
    run_word(32'h3E12_3456, 0, 0, 0, 0, 0);   // R7 left cond, flag clear
    run_word(32'h0123_7C55, 0, 0, 1, 1, 0);   // R7 right cond first, flag set
    run_word(32'h0123_7C55, 0, 0, 0, 0, 0);   // R7 right cond, flag clear
    run_word(32'h3E00_7C01, 0, 0, 1, 0, 0);   // R7 both cond, left first
    run_word(32'h4321_0FED, 0, 0, 0, 4, 1);   // R8 R10 long stall with stray valid
    run_word(32'hC765_4321, 0, 0, 0, 3, 1);   // R10 stray valid during long op

    repeat (6) begin
      @(negedge clk);
      check(op_valid == 1'b0 && word_done == 1'b0, "R10 idle after stray",
            {38'd0, op_valid, word_done}, 40'h0);
    end
    check(exp_q.size() == 0, "R9 all items seen", exp_q.size(), 40'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule